// File: doc/BRIEF.md
# Dynamic-Round ARX Block Cipher Pipeline

This block encrypts a 16-bit data block in a fully unrolled pipeline of eight registered rounds. The block is split into four 4-bit words. Each round mixes them with four round subkeys using modulo-16 addition, XOR, 4-bit right rotation and a Boolean combining function. The Boolean function and the rotation amounts both depend on the round index, so no two adjacent rounds behave the same. The last round also XORs four extra whitening subkeys into its output words.

The caller supplies a flat bus of 36 precomputed 4-bit subkeys and holds it steady while blocks are in flight. A new plaintext may enter on every clock cycle, marked by a valid strobe. Its ciphertext appears, with its own valid strobe, exactly eight cycles later. Gaps in the input strobe travel through the pipeline unchanged.

Top module: `arx_cipher_pipe`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is low, and it stays low until a valid input has travelled through the pipe.
- R2: A block accepted at rising edge N (with `in_valid` high) is presented with `out_valid` high after rising edge N+8, which is eight cycles of latency.
- R3: Each round r (0..7) computes the following, in this order:
  - w1 += k1 and w2 += k2 (mod 16);
  - w0 ^= rotr(A_r(w2,k0), a_r) and w3 ^= rotr(B_r(w1,k3), b_r);
  - w1 ^= w0 and w2 ^= w3;
  - w0 = rotr(w0, b_r) and w3 = rotr(w3, a_r);
  - the words are then reordered so that the new (w0,w1,w2,w3) equals the old (w2,w0,w3,w1).
  
  The combining functions are A_r = x&k and B_r = x|~k for even r, and A_r = x|k and B_r = x&~k for odd r. The rotation amounts are a_r = (r mod 3)+1 and b_r = 3-(r mod 3).
- R4: A block may be accepted on every cycle. Back-to-back blocks each produce their own correct ciphertext, in input order.
- R5: `out_valid` is high once per accepted block and at no other time. Input bubbles appear at the output eight cycles later.
- R6: Word i of the plaintext is `plain_blk[4i+3:4i]`, and the ciphertext is packed as {w3,w2,w1,w0} with w0 in the low bits. Subkey n sits in `subkey_bus[4n+3:4n]`, and round r uses subkey 4r+j as kj.
- R7: After round 7, subkey 32+i is XORed into output word i. A change of d in subkey 33 alone therefore changes only `cipher_blk[7:4]`, by exactly d.
- R8: `cipher_blk` holds its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext strobe |
| plain_blk | input | 16 | Plaintext block |
| subkey_bus | input | 144 | 36 round and whitening subkeys, 4 bits each |
| out_valid | output | 1 | Ciphertext strobe |
| cipher_blk | output | 16 | Ciphertext block |

## Verification
The hardest state to reach from the ports is a pipe in which every stage holds a different block and bubbles sit between some of them. Only this state shows whether the valid tracking and the per-stage data enables stay aligned. Random valid patterns reach it by mixing long back-to-back bursts with scattered idle cycles. A monitor pairs each output with the input cycle that produced it. The whitening path cannot be seen apart from the eight rounds, so it is isolated differentially. The same plaintext is encrypted twice with only one whitening subkey changed, and the two ciphertexts must differ in exactly that word.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;
  localparam int WORD_W  = 4;
  localparam int N_WORDS = 4;
  localparam int BLK_W   = WORD_W * N_WORDS;
  localparam int RKEY_W  = N_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int n);
    int s;
    s = n % WORD_W;
    if (s == 0) return x;
    return word_t'((x >> s) | (x << (WORD_W - s)));
  endfunction

  function automatic int rot_a(input int r);
    return (r % 3) + 1;
  endfunction

  function automatic int rot_b(input int r);
    return 3 - (r % 3);
  endfunction

  function automatic word_t comb_a(input word_t x, input word_t k, input int r);
    return ((r % 2) == 0) ? (x & k) : (x | k);
  endfunction

  function automatic word_t comb_b(input word_t x, input word_t k, input int r);
    return ((r % 2) == 0) ? (x | ~k) : (x & ~k);
  endfunction
endpackage

// File: rtl/arx_mix.sv
`timescale 1ns/1ps
module arx_mix
  import arx_pkg::*;
#(
  parameter int ROUND_IDX = 0,
  parameter bit SIDE_B    = 1'b0
) (
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] k,
  output logic [WORD_W-1:0] y
);
  generate
    if (SIDE_B) begin : g_side_b
      localparam int ROT = rot_b(ROUND_IDX);
      assign y = rotr(comb_b(x, k, ROUND_IDX), ROT);
    end else begin : g_side_a
      localparam int ROT = rot_a(ROUND_IDX);
      assign y = rotr(comb_a(x, k, ROUND_IDX), ROT);
    end
  endgenerate
endmodule

// File: rtl/arx_round.sv
`timescale 1ns/1ps
module arx_round
  import arx_pkg::*;
#(
  parameter int ROUND_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [BLK_W-1:0]  in_blk,
  input  logic [RKEY_W-1:0] rkeys,
  input  logic [BLK_W-1:0]  wmask,
  output logic              out_vld,
  output logic [BLK_W-1:0]  out_blk
);
  localparam int RA = rot_a(ROUND_IDX);
  localparam int RB = rot_b(ROUND_IDX);

  word_t w0, w1, w2, w3;
  word_t k0, k1, k2, k3;
  word_t s1, s2, mix_a, mix_b, t0, t3, u1, u2, v0, v3;
  logic [BLK_W-1:0] nxt;

  assign {w3, w2, w1, w0} = in_blk;
  assign {k3, k2, k1, k0} = rkeys;

  assign s1 = w1 + k1;
  assign s2 = w2 + k2;

  arx_mix #(.ROUND_IDX(ROUND_IDX), .SIDE_B(1'b0)) u_mix_a (
    .x(s2), .k(k0), .y(mix_a)
  );
  arx_mix #(.ROUND_IDX(ROUND_IDX), .SIDE_B(1'b1)) u_mix_b (
    .x(s1), .k(k3), .y(mix_b)
  );

  assign t0 = w0 ^ mix_a;
  assign t3 = w3 ^ mix_b;
  assign u1 = s1 ^ t0;
  assign u2 = s2 ^ t3;
  assign v0 = rotr(t0, RB);
  assign v3 = rotr(t3, RA);

  // reorder: new w0=u2, w1=v0, w2=v3, w3=u1
  assign nxt = {u1, v3, v0, u2} ^ wmask;

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
    if (in_vld && !rst) out_blk <= nxt;
  end
endmodule

// File: rtl/arx_cipher_pipe.sv
`timescale 1ns/1ps
module arx_cipher_pipe
  import arx_pkg::*;
#(
  parameter int ROUNDS = 8,
  localparam int N_KEYS = N_WORDS * ROUNDS + N_WORDS,
  localparam int KEY_W  = N_KEYS * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] plain_blk,
  input  logic [KEY_W-1:0] subkey_bus,
  output logic             out_valid,
  output logic [BLK_W-1:0] cipher_blk
);
  logic             stg_vld [0:ROUNDS];
  logic [BLK_W-1:0] stg_blk [0:ROUNDS];

  assign stg_vld[0] = in_valid;
  assign stg_blk[0] = plain_blk;

  generate
    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
      logic [BLK_W-1:0] wmask;
      if (r == ROUNDS - 1) begin : g_whiten
        assign wmask = subkey_bus[ROUNDS*RKEY_W +: BLK_W];
      end else begin : g_plain
        assign wmask = '0;
      end
      arx_round #(.ROUND_IDX(r)) u_round (
        .clk    (clk),
        .rst    (rst),
        .in_vld (stg_vld[r]),
        .in_blk (stg_blk[r]),
        .rkeys  (subkey_bus[r*RKEY_W +: RKEY_W]),
        .wmask  (wmask),
        .out_vld(stg_vld[r+1]),
        .out_blk(stg_blk[r+1])
      );
    end
  endgenerate

  assign out_valid  = stg_vld[ROUNDS];
  assign cipher_blk = stg_blk[ROUNDS];
endmodule

// File: rtl/arx_cipher_pipe_chk.sv
`timescale 1ns/1ps
module arx_cipher_pipe_chk #(
  parameter int ROUNDS = 8,
  parameter int BLK_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [BLK_W-1:0] cipher_blk
);
  logic [ROUNDS-1:0] vhist;

  always_ff @(posedge clk) begin
    if (rst) vhist <= '0;
    else     vhist <= (vhist << 1) | ROUNDS'(in_valid);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    vhist[ROUNDS-1] |-> out_valid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !vhist[ROUNDS-1] |-> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(cipher_blk));
endmodule

bind arx_cipher_pipe arx_cipher_pipe_chk #(.ROUNDS(ROUNDS), .BLK_W(arx_pkg::BLK_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .cipher_blk(cipher_blk)
);

// File: tb/arx_cipher_pipe_tb.sv
`timescale 1ns/1ps
module arx_cipher_pipe_tb;
  localparam int KW = 144;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [15:0]   plain_blk = '0;
  logic [KW-1:0] keys = '0;
  logic          out_valid;
  logic [15:0]   cipher_blk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R3";
  logic [15:0] exp_q[$];
  int          cyc_q[$];
  logic [15:0] last_ct, prev_ct;
  logic        seen = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  arx_cipher_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .plain_blk(plain_blk),
    .subkey_bus(keys), .out_valid(out_valid), .cipher_blk(cipher_blk)
  );

  function automatic logic [3:0] rr(input logic [3:0] x, input int n);
    logic [7:0] d;
    d = {x, x} >> n;
    return d[3:0];
  endfunction

  function automatic logic [15:0] ref_ct(input logic [15:0] p, input logic [KW-1:0] k);
    logic [3:0] w[4];
    logic [3:0] kk[4];
    logic [3:0] f, g, n0, n1, n2, n3;
    int a, b;
    for (int i = 0; i < 4; i++) w[i] = p[4*i +: 4];
    for (int r = 0; r < 8; r++) begin
      for (int j = 0; j < 4; j++) kk[j] = k[(4*r+j)*4 +: 4];
      a = (r % 3) + 1;
      b = 3 - (r % 3);
      w[1] = w[1] + kk[1];
      w[2] = w[2] + kk[2];
      if (r % 2 == 0) begin f = w[2] & kk[0]; g = w[1] | ~kk[3]; end
      else            begin f = w[2] | kk[0]; g = w[1] & ~kk[3]; end
      w[0] = w[0] ^ rr(f, a);
      w[3] = w[3] ^ rr(g, b);
      w[1] = w[1] ^ w[0];
      w[2] = w[2] ^ w[3];
      w[0] = rr(w[0], b);
      w[3] = rr(w[3], a);
      n0 = w[2]; n1 = w[0]; n2 = w[3]; n3 = w[1];
      w[0] = n0; w[1] = n1; w[2] = n2; w[3] = n3;
    end
    for (int i = 0; i < 4; i++) w[i] = w[i] ^ k[(32+i)*4 +: 4];
    return {w[3], w[2], w[1], w[0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [15:0] p);
    @(posedge clk); #1;
    in_valid  = 1'b1;
    plain_blk = p;
    exp_q.push_back(ref_ct(p, keys));
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  // monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R5", 16'(out_valid), 16'h0);
        end else begin
          check(cur_req, cipher_blk, exp_q.pop_front());
          check("R2", 16'(cyc - cyc_q.pop_front()), 16'd8);
        end
        last_ct = cipher_blk;
        seen = 1'b1;
      end else if (seen) begin
        check("R8", cipher_blk, prev_ct);
      end
      prev_ct = cipher_blk;
    end
  end

  initial begin
    logic [15:0] c1, c2;
    logic [3:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 16'(out_valid), 16'h0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1", 16'(out_valid), 16'h0);
    idle(4);
    check("R1", 16'(out_valid), 16'h0);

    // R6: single-bit and edge patterns with all-zero and all-one keys
    cur_req = "R6";
    issue(16'h0000); issue(16'h0001); issue(16'h0010); issue(16'h8000);
    issue(16'hFFFF);
    idle(12);
    keys = '1;
    issue(16'h0000); issue(16'h0100); issue(16'hA5C3);
    idle(12);

    // R6: a single nonzero subkey at a time locates the key slots
    for (int n = 0; n < 36; n += 7) begin
      keys = '0;
      keys[4*n +: 4] = 4'h9;
      issue(16'h3C5A);
      idle(10);
    end

    // R4: back-to-back burst with random keys
    cur_req = "R4";
    for (int i = 0; i < 5; i++) keys[32*i +: 32] = $urandom;
    for (int i = 0; i < 40; i++) issue(16'($urandom));
    idle(12);

    // R3/R5: random valid pattern with bubbles, several key sets
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 5; i++) keys[32*i +: 32] = $urandom;
      for (int i = 0; i < 300; i++) begin
        if ($urandom % 10 < 7) issue(16'($urandom));
        else idle(1 + $urandom % 3);
      end
      idle(12);
    end

    // R7: whitening subkey 33 changes only word 1
    cur_req = "R7";
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 5; i++) keys[32*i +: 32] = $urandom;
      d = 4'($urandom % 15 + 1);
      issue(16'($urandom ^ t));
      idle(12);
      c1 = last_ct;
      keys[33*4 +: 4] = keys[33*4 +: 4] ^ d;
      issue(plain_blk);
      idle(12);
      c2 = last_ct;
      check("R7", c1 ^ c2, {8'h00, d, 4'h0});
    end

    check("R5", 16'(exp_q.size()), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule